// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver with Noise Detection

This block recovers characters from an asynchronous NRZ serial line. The line idles high. A character starts with a low start bit, carries 8 or 9 data bits with the least significant bit first, and ends with a single high stop bit. The block is paced by a one-cycle sample enable that pulses sixteen times per bit period. A mode input selects 8-bit or 9-bit characters.

Within each bit the receiver takes three samples around the centre and resolves the bit value by majority. If those three samples disagree in any bit of the character, including the start bit, the block reports noise. Completed characters move from the shift stage into a holding register, so one character can wait while the next one arrives. In 9-bit mode the extra bit appears on its own output. The host sees four status outputs: character waiting, overrun, noise and framing error. The host clears them by pulsing a status-read strobe and then a data-read strobe.

Top module: `nrz_receiver`

## Requirements
- R1: After reset, the waiting, overrun, noise and framing flags are 0 and the held character is 0.
- R2: In 8-bit mode (mode input 0), a frame of start bit 0, eight data bits LSB first and stop bit 1 appears on the data output with the waiting flag set, and the ninth-bit output is 0.
- R3: In 9-bit mode (mode input 1), the first eight data bits received appear on the data output and the ninth received bit appears on the ninth-bit output.
- R4: Each bit's value is the majority of samples 7, 8 and 9, counted from sample 1 at the first sample enable that sees the line low. A single sample that disagrees with the other two of those three does not change the value.
- R5: The noise flag is set with the character if samples 7, 8 and 9 disagree in any bit, the start bit included. A disagreeing sample outside positions 7 to 9 does not set it.
- R6: A stop bit resolved as 0 sets the framing flag. The character is still loaded and the waiting flag is still set.
- R7: If a character completes while the waiting flag is set, the overrun flag is set, the new character is dropped and the held data stays unchanged.
- R8: If the start bit resolves to 1 at its middle samples, the receiver returns to idle without loading a character. It then receives the next valid frame normally.
- R9: A data-read pulse clears all four flags only if a status-read pulse came earlier with no data read in between. A data-read pulse on its own leaves every flag as it was.
- R10: The line is looked at only on sample-enable cycles. A low pulse on the line with no sample enable during it starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| status_rd | input | 1 | Host has read the status |
| data_rd | input | 1 | Host reads the held character |
| rx_data | output | 8 | Held character, low eight bits |
| rx_bit8 | output | 1 | Held ninth bit (9-bit mode) |
| rx_full | output | 1 | Character waiting |
| rx_overrun | output | 1 | Character lost because the holding register was full |
| rx_noise | output | 1 | Centre samples disagreed in the held character |
| rx_frame_err | output | 1 | Stop bit resolved as 0 |

## Verification
The hardest case to reach is a single stray sample at a chosen position within a chosen bit. A noise-flag mismatch, or a wrong vote, only shows up when exactly one of samples 7, 8 or 9 differs. The bench therefore produces every sample enable itself and drives the line one sample slot at a time. This lets it place a one-sample glitch at any position of any bit, including the start bit. It compares glitches inside and outside the centre window, and it also drives a start bit whose centre reads high to provoke a false start.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_vote.sv
module srx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_first,
  input  logic cap_second,
  input  logic line,
  output logic vote,
  output logic unanimous
);
  logic s_a_q, s_b_q, s_a_d, s_b_d;

  always_comb begin
    s_a_d = cap_first  ? line : s_a_q;
    s_b_d = cap_second ? line : s_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else begin
      s_a_q <= s_a_d;
      s_b_q <= s_b_d;
    end
  end

  // Third sample is the live line at the deciding enable.
  assign vote      = (s_a_q & s_b_q) | (s_a_q & line) | (s_b_q & line);
  assign unanimous = (s_a_q == s_b_q) && (s_b_q == line);
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          nine,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          bit8_o,
  output logic          noise_o,
  output logic          ferr_o
);
  localparam int CW    = $clog2(OVS);
  localparam int IW    = CW + 1;
  localparam int BW    = $clog2(DW + 1);
  localparam int MID_A = OVS / 2 - 1;
  localparam int MID_B = OVS / 2;
  localparam int MID_C = OVS / 2 + 1;

  srx_state_e st_q, st_d;
  logic [CW-1:0] smp_q, smp_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW:0]   sh_q, sh_d;
  logic          nz_q, nz_d;
  logic          done_d, noise_d, ferr_d, bit8_d;
  logic [DW-1:0] data_d;
  logic [IW-1:0] idx;
  logic [BW-1:0] last_bit;
  logic          in_bit, decide, last_slot, vote, unan;

  assign idx       = {1'b0, smp_q} + IW'(1);
  assign in_bit    = (st_q != ST_IDLE);
  assign decide    = tick && in_bit && (idx == IW'(MID_C));
  assign last_slot = (idx == IW'(OVS));
  assign last_bit  = nine ? BW'(DW) : BW'(DW - 1);

  srx_vote u_vote (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_first  (tick && in_bit && (idx == IW'(MID_A))),
    .cap_second (tick && in_bit && (idx == IW'(MID_B))),
    .line       (line),
    .vote       (vote),
    .unanimous  (unan)
  );

  always_comb begin
    st_d    = st_q;
    smp_d   = smp_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    nz_d    = nz_q;
    done_d  = 1'b0;
    data_d  = data_o;
    bit8_d  = bit8_o;
    noise_d = noise_o;
    ferr_d  = ferr_o;
    unique case (st_q)
      ST_IDLE: begin
        if (tick && !line) begin
          st_d  = ST_START;
          smp_d = CW'(1);
          nz_d  = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          smp_d = idx[CW-1:0];
          if (decide) begin
            if (vote) st_d = ST_IDLE;
            else      nz_d = nz_q | ~unan;
          end
          if (last_slot) begin
            st_d  = ST_DATA;
            bit_d = '0;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          smp_d = idx[CW-1:0];
          if (decide) begin
            sh_d = {vote, sh_q[DW:1]};
            nz_d = nz_q | ~unan;
          end
          if (last_slot) begin
            if (bit_q == last_bit) st_d = ST_STOP;
            else                   bit_d = bit_q + BW'(1);
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          smp_d = idx[CW-1:0];
          if (decide) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            noise_d = nz_q | ~unan;
            ferr_d  = ~vote;
            data_d  = nine ? sh_q[DW-1:0] : sh_q[DW:1];
            bit8_d  = nine & sh_q[DW];
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      smp_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      nz_q    <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      bit8_o  <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      smp_q   <= smp_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      nz_q    <= nz_d;
      done_o  <= done_d;
      data_o  <= data_d;
      bit8_o  <= bit8_d;
      noise_o <= noise_d;
      ferr_o  <= ferr_d;
    end
  end

  // Data bit counter never passes the ninth position (R3)
  assert_bit_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (bit_q <= BW'(DW)));
  // A completed frame leaves the receiver idle (R2)
  assert_done_returns_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (st_q == ST_IDLE));
  // Nothing leaves idle without a sample enable (R10)
  assert_idle_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !tick) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] f_data,
  input  logic          f_bit8,
  input  logic          f_noise,
  input  logic          f_ferr,
  input  logic          status_rd,
  input  logic          data_rd,
  output logic [DW-1:0] data_q,
  output logic          bit8_q,
  output logic          full_q,
  output logic          ovr_q,
  output logic          nf_q,
  output logic          fe_q
);
  logic          armed_q, armed_d, clear_now;
  logic [DW-1:0] data_d;
  logic          bit8_d, full_d, ovr_d, nf_d, fe_d;

  assign clear_now = data_rd && armed_q;

  always_comb begin
    armed_d = armed_q;
    if (status_rd)    armed_d = 1'b1;
    else if (data_rd) armed_d = 1'b0;

    data_d = data_q;
    bit8_d = bit8_q;
    full_d = clear_now ? 1'b0 : full_q;
    ovr_d  = clear_now ? 1'b0 : ovr_q;
    nf_d   = clear_now ? 1'b0 : nf_q;
    fe_d   = clear_now ? 1'b0 : fe_q;
    if (done) begin
      if (full_d) begin
        ovr_d = 1'b1;
      end else begin
        data_d = f_data;
        bit8_d = f_bit8;
        full_d = 1'b1;
        nf_d   = nf_d | f_noise;
        fe_d   = fe_d | f_ferr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      data_q  <= '0;
      bit8_q  <= 1'b0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      nf_q    <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      data_q  <= data_d;
      bit8_q  <= bit8_d;
      full_q  <= full_d;
      ovr_q   <= ovr_d;
      nf_q    <= nf_d;
      fe_q    <= fe_d;
    end
  end

  // Overrun only while a character was waiting (R7)
  assert_overrun_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(full_q));
  // Held character is not overwritten while waiting (R7)
  assert_hold_while_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clear_now) |=> $stable(data_q));
  // Waiting flag comes only from a completed frame (R2)
  assert_full_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done));
  // Framing flag comes only from a completed frame (R6)
  assert_ferr_from_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_q) |-> $past(done));
  // Flags drop only on an armed data read (R9)
  assert_clear_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(clear_now));
endmodule

// File: rtl/nrz_receiver.sv
module nrz_receiver #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic          rx_line,
  input  logic          nine_bit,
  input  logic          status_rd,
  input  logic          data_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_full,
  output logic          rx_overrun,
  output logic          rx_noise,
  output logic          rx_frame_err
);
  logic          line_s, f_done, f_bit8, f_noise, f_ferr;
  logic [DW-1:0] f_data;

  srx_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (line_s)
  );

  srx_framer #(.OVS(OVS), .DW(DW)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_en),
    .line    (line_s),
    .nine    (nine_bit),
    .done_o  (f_done),
    .data_o  (f_data),
    .bit8_o  (f_bit8),
    .noise_o (f_noise),
    .ferr_o  (f_ferr)
  );

  srx_holding #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (f_done),
    .f_data    (f_data),
    .f_bit8    (f_bit8),
    .f_noise   (f_noise),
    .f_ferr    (f_ferr),
    .status_rd (status_rd),
    .data_rd   (data_rd),
    .data_q    (rx_data),
    .bit8_q    (rx_bit8),
    .full_q    (rx_full),
    .ovr_q     (rx_overrun),
    .nf_q      (rx_noise),
    .fe_q      (rx_frame_err)
  );
endmodule

// File: tb/tb_nrz_receiver.sv
module tb_nrz_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b0;
  logic       rx_line = 1'b1;
  logic       nine_bit = 1'b0;
  logic       status_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, rx_overrun, rx_noise, rx_frame_err;
  int         n_checks = 0;
  int         n_errors = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  nrz_receiver dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_line(rx_line),
    .nine_bit(nine_bit), .status_rd(status_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sample slot: set line, let the synchronizer settle, then one enable
  task automatic slot(input logic v);
    rx_line = v;
    repeat (3) @(negedge clk);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int gpos);
    for (int s = 1; s <= 16; s++) slot((s == gpos) ? ~v : v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  // gbit: 0 start, 1..n data, n+1 stop, -1 none
  task automatic send_frame(input logic [8:0] d, input logic nine, input int gbit,
                            input int gpos, input logic stopv);
    int n;
    n = nine ? 9 : 8;
    send_bit(1'b0, (gbit == 0) ? gpos : 0);
    for (int b = 0; b < n; b++) send_bit(d[b], (gbit == b + 1) ? gpos : 0);
    send_bit(stopv, (gbit == n + 1) ? gpos : 0);
    idle(20);
  endtask

  task automatic pulse_status();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
  endtask

  task automatic host_clear();
    pulse_status();
    pulse_data();
  endtask

  task automatic check_flags(input string req, input logic f, input logic o,
                             input logic nz, input logic fe);
    chk({req, " full"},    rx_full, f);
    chk({req, " overrun"}, rx_overrun, o);
    chk({req, " noise"},   rx_noise, nz);
    chk({req, " framing"}, rx_frame_err, fe);
  endtask

  task automatic t_reset();
    check_flags("R1 reset", 0, 0, 0, 0);
    chk("R1 reset data", rx_data, 8'h00);
  endtask

  task automatic t_basic();
    nine_bit = 1'b0;
    send_frame(9'h0A5, 1'b0, -1, 0, 1'b1);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R2 bit8", rx_bit8, 1'b0);
    check_flags("R2 A5", 1, 0, 0, 0);
    host_clear();
    check_flags("R9 after clear", 0, 0, 0, 0);
    send_frame(9'h03C, 1'b0, -1, 0, 1'b1);
    chk("R2 data 3C", rx_data, 8'h3C);
    chk("R2 full 3C", rx_full, 1'b1);
    host_clear();
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send_frame(9'h15A, 1'b1, -1, 0, 1'b1);
    chk("R3 data 5A", rx_data, 8'h5A);
    chk("R3 bit8 1", rx_bit8, 1'b1);
    host_clear();
    send_frame(9'h0C3, 1'b1, -1, 0, 1'b1);
    chk("R3 data C3", rx_data, 8'hC3);
    chk("R3 bit8 0", rx_bit8, 1'b0);
    host_clear();
    nine_bit = 1'b0;
  endtask

  task automatic t_noise();
    send_frame(9'h096, 1'b0, 4, 8, 1'b1);     // glitch data bit 3, sample 8
    chk("R4 vote keeps 96", rx_data, 8'h96);
    chk("R5 noise centre", rx_noise, 1'b1);
    host_clear();
    send_frame(9'h096, 1'b0, 2, 7, 1'b1);     // glitch data bit 1, sample 7
    chk("R4 vote keeps 96 s7", rx_data, 8'h96);
    chk("R5 noise s7", rx_noise, 1'b1);
    host_clear();
    send_frame(9'h069, 1'b0, 5, 3, 1'b1);     // glitch outside window
    chk("R5 data 69", rx_data, 8'h69);
    chk("R5 no noise outside", rx_noise, 1'b0);
    host_clear();
    send_frame(9'h011, 1'b0, 0, 9, 1'b1);     // glitch in start bit, sample 9
    chk("R5 start data 11", rx_data, 8'h11);
    chk("R5 start noise", rx_noise, 1'b1);
    host_clear();
  endtask

  task automatic t_framing();
    send_frame(9'h0E7, 1'b0, -1, 0, 1'b0);
    chk("R6 data E7", rx_data, 8'hE7);
    check_flags("R6", 1, 0, 0, 1);
    host_clear();
    idle(20);
    check_flags("R6 cleared", 0, 0, 0, 0);
  endtask

  task automatic t_overrun();
    send_frame(9'h042, 1'b0, -1, 0, 1'b1);
    send_frame(9'h0BD, 1'b0, -1, 0, 1'b1);
    chk("R7 data kept", rx_data, 8'h42);
    check_flags("R7", 1, 1, 0, 0);
    host_clear();
    check_flags("R7 cleared", 0, 0, 0, 0);
  endtask

  task automatic t_false_start();
    for (int s = 1; s <= 6; s++) slot(1'b0);
    idle(40);
    chk("R8 no char", rx_full, 1'b0);
    send_frame(9'h5E, 1'b0, -1, 0, 1'b1);
    chk("R8 recovers", rx_data, 8'h5E);
    chk("R8 recovers full", rx_full, 1'b1);
    host_clear();
  endtask

  task automatic t_data_only();
    send_frame(9'h0F0, 1'b0, 3, 8, 1'b1);
    pulse_data();
    check_flags("R9 data-only", 1, 0, 1, 0);
    pulse_status();
    check_flags("R9 status-only", 1, 0, 1, 0);
    pulse_data();
    check_flags("R9 armed read", 0, 0, 0, 0);
  endtask

  task automatic t_no_tick();
    rx_line = 1'b0;
    repeat (200) @(negedge clk);
    rx_line = 1'b1;
    idle(40);
    chk("R10 no frame", rx_full, 1'b0);
    chk("R10 no framing", rx_frame_err, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_nine();
    t_noise();
    t_framing();
    t_overrun();
    t_false_start();
    t_data_only();
    t_no_tick();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule